// File: doc/BRIEF.md
# Key Event Queue with Interrupt Control

This block sits between a keypad scanner and a host register interface. The scanner hands over debounced key events one at a time, each a 6-bit key code plus a pressed/released flag, and marks the final event of a batch. The host drains the events through a single status byte. Each pop strobe removes the event currently shown. Events come out in ascending key-code order whatever order they arrived in. Bit 7 of the byte tells the host whether more events follow.

An active-low interrupt goes low when a batch has been stored. It stays low until the last event is read. While it is low the block raises a busy flag, and any event the scanner offers is discarded. An optional timeout, selected by a 2-bit code and counted in millisecond ticks, can release the interrupt early. The stored events then stay readable, but the first event of a new batch throws them away and starts a fresh store.

Top module: `kev_top`

## Requirements
- R1: The status byte is `{more, pressed, code[5:0]}`. Bit 7 is 1 when at least one other event is stored behind the one shown. Bit 6 is 1 for a press and 0 for a release. Bits 5:0 are the key code.
- R2: Stored events are presented and popped in strictly ascending key-code order, independent of arrival order.
- R3: The store holds at most 16 events. An event pushed when the store is full is dropped, and the sticky output `ovf_seen` goes to 1 and stays there until reset.
- R4: An accepted push with `ev_last` = 1 drives `int_n` low on the next clock edge. While `int_n` is low, `busy` is 1 and every push is ignored.
- R5: `int_n` stays low until the pop that removes the final stored event. After that edge `int_n` is 1 and the status byte reads 00h.
- R6: With `aci` = 01 or 10, if no pop occurs, `int_n` returns high on the clock edge that samples the 5th or 10th `ms_tick` counted since it went low. With `aci` = 00 or 11 there is no timeout.
- R7: After a timeout the stored events stay unchanged and can be popped while `int_n` is high.
- R8: If the interrupt was released by timeout with events still stored, the next accepted push that opens a batch discards every stored event first. Only the new batch is then readable, and `int_n` asserts again when the batch closes.
- R9: A pop while the store is empty has no effect. The status byte reads 00h and `int_n` does not change.
- R10: After reset the store is empty, the status byte is 00h, `int_n` = 1, `busy` = 0 and `ovf_seen` = 0.
- R11: A pop made while `int_n` is low cancels the timeout for that assertion. `int_n` then stays low until the store is drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_push | input | 1 | Scanner offers one key event this cycle |
| ev_code | input | 6 | Key code of the offered event |
| ev_pressed | input | 1 | 1 = press, 0 = release |
| ev_last | input | 1 | Offered event closes the batch |
| pop | input | 1 | Host consumes the event shown in `status` |
| aci | input | 2 | Timeout select: 00 off, 01 short, 10 long, 11 off |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| status | output | 8 | Status byte of the lowest-coded stored event |
| int_n | output | 1 | Active-low interrupt |
| busy | output | 1 | Interrupt pending; scanner must hold off |
| ovf_seen | output | 1 | Sticky: an event was dropped on a full store |

## Verification
The hardest state to reach is a stale store. This is a store left holding events after the timeout fired. It is the only state in which the discard-on-new-batch path and reads with the interrupt high are active. The stimulus stores two events, pops none, and pulses `ms_tick` exactly up to the timeout limit, checking the interrupt on the tick just before the limit and on the limit itself. It then pops one event with the interrupt high. Finally it opens a new batch and confirms that only the new event can be read. A separate scenario pops once before the limit and then sends well over the tick count, to show that the read cancels the timeout.

// File: rtl/kev_pkg.sv
package kev_pkg;

  localparam int unsigned KEV_CODE_W = 6;

  typedef struct packed {
    logic                  pressed;
    logic [KEV_CODE_W-1:0] code;
  } kev_t;

  typedef enum logic [1:0] {
    ACI_OFF   = 2'b00,
    ACI_SHORT = 2'b01,
    ACI_LONG  = 2'b10,
    ACI_RSVD  = 2'b11
  } aci_e;

  // Host-visible byte: more flag, press flag, key code.
  function automatic logic [7:0] kev_status(input logic more, input kev_t ev);
    return {more, ev.pressed, ev.code};
  endfunction

  // Tick count after which the interrupt self-releases; 0 means never.
  function automatic int unsigned kev_limit(input logic [1:0] sel,
                                            input int unsigned t_short,
                                            input int unsigned t_long);
    case (aci_e'(sel))
      ACI_SHORT: return t_short;
      ACI_LONG:  return t_long;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/kev_store.sv
module kev_store
  import kev_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  kev_t             wr_ev,
  input  logic             flush,
  input  logic             rd_en,
  output kev_t             head,
  output logic [OCC_W-1:0] occ,
  output logic             full,
  output logic             ovf_seen
);

  logic [DEPTH-1:0] valid_q;
  kev_t             ev_q [DEPTH];
  logic [IDX_W-1:0] head_idx;
  logic [IDX_W-1:0] free_idx;
  logic             head_found;
  logic             free_found;
  logic             drop;

  // Lowest-coded valid slot.
  always_comb begin
    head_idx   = '0;
    head_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_q[i] && (!head_found || (ev_q[i].code < ev_q[head_idx].code))) begin
        head_idx   = IDX_W'(i);
        head_found = 1'b1;
      end
    end
  end

  // First empty slot.
  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_q[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < DEPTH; i++) begin
      occ = occ + OCC_W'(valid_q[i]);
    end
  end

  assign full = !free_found;
  assign head = head_found ? ev_q[head_idx] : '0;
  assign drop = wr_en && !flush && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      ovf_seen <= 1'b0;
    end else begin
      if (flush) begin
        valid_q    <= '0;
        valid_q[0] <= 1'b1;
      end else begin
        if (rd_en && head_found) valid_q[head_idx] <= 1'b0;
        if (wr_en && free_found) valid_q[free_idx] <= 1'b1;
      end
      if (drop) ovf_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (flush) begin
      ev_q[0] <= wr_ev;
    end else if (wr_en && free_found) begin
      ev_q[free_idx] <= wr_ev;
    end
  end

endmodule

// File: rtl/kev_irq.sv
module kev_irq
  import kev_pkg::*;
#(
  parameter int unsigned TMO_SHORT = 5,
  parameter int unsigned TMO_LONG  = 10,
  localparam int unsigned TMR_W = $clog2(TMO_LONG + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] aci,
  input  logic       ms_tick,
  input  logic       accept,
  input  logic       ev_last,
  input  logic       pop_hit,
  input  logic       pop_empties,
  input  logic       flush,
  output logic       int_act,
  output logic       stale,
  output logic       batch_open,
  output logic       tmo_fire
);

  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] limit;
  logic             read_seen;
  logic             commit;

  assign limit  = TMR_W'(kev_limit(aci, TMO_SHORT, TMO_LONG));
  assign commit = accept && ev_last;

  assign tmo_fire = int_act && !read_seen && !pop_hit && ms_tick &&
                    (limit != '0) && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_act    <= 1'b0;
      stale      <= 1'b0;
      batch_open <= 1'b0;
      read_seen  <= 1'b0;
      cnt_q      <= '0;
    end else begin
      if (accept) batch_open <= !ev_last;

      if (commit) begin
        int_act   <= 1'b1;
        read_seen <= 1'b0;
        cnt_q     <= '0;
      end else if (int_act) begin
        if (pop_empties || tmo_fire) int_act <= 1'b0;
        if (pop_hit) read_seen <= 1'b1;
        if (ms_tick && !read_seen && (limit != '0)) cnt_q <= cnt_q + 1'b1;
      end

      if (tmo_fire) stale <= 1'b1;
      else if (pop_empties || flush) stale <= 1'b0;
    end
  end

endmodule

// File: rtl/kev_top.sv
module kev_top
  import kev_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned TMO_SHORT = 5,
  parameter int unsigned TMO_LONG  = 10,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_push,
  input  logic [KEV_CODE_W-1:0] ev_code,
  input  logic                  ev_pressed,
  input  logic                  ev_last,
  input  logic                  pop,
  input  logic [1:0]            aci,
  input  logic                  ms_tick,
  output logic [7:0]            status,
  output logic                  int_n,
  output logic                  busy,
  output logic                  ovf_seen
);

  kev_t             wr_ev;
  kev_t             head;
  logic [OCC_W-1:0] occ;
  logic             full;
  logic             int_act;
  logic             stale;
  logic             batch_open;
  logic             tmo_fire;

  // Named internal events.
  logic accept;
  logic flush_req;
  logic pop_eff;
  logic pop_empties;
  logic stored;

  assign wr_ev       = '{pressed: ev_pressed, code: ev_code};
  assign accept      = ev_push && !int_act;
  assign flush_req   = accept && stale && !batch_open;
  assign pop_eff     = pop && (occ != '0) && !flush_req;
  assign stored      = accept && (flush_req || !full);
  assign pop_empties = pop_eff && (occ == OCC_W'(1)) && !stored;

  kev_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept),
    .wr_ev    (wr_ev),
    .flush    (flush_req),
    .rd_en    (pop_eff),
    .head     (head),
    .occ      (occ),
    .full     (full),
    .ovf_seen (ovf_seen)
  );

  kev_irq #(.TMO_SHORT(TMO_SHORT), .TMO_LONG(TMO_LONG)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .aci         (aci),
    .ms_tick     (ms_tick),
    .accept      (accept),
    .ev_last     (ev_last),
    .pop_hit     (pop_eff),
    .pop_empties (pop_empties),
    .flush       (flush_req),
    .int_act     (int_act),
    .stale       (stale),
    .batch_open  (batch_open),
    .tmo_fire    (tmo_fire)
  );

  assign status = (occ == '0) ? 8'h00 : kev_status(occ > OCC_W'(1), head);
  assign int_n  = !int_act;
  assign busy   = int_act;

endmodule

// File: rtl/kev_chk.sv
module kev_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_push,
  input logic             ev_last,
  input logic             pop,
  input logic             busy,
  input logic             int_n,
  input logic [7:0]       status,
  input logic [OCC_W-1:0] occ,
  input logic             accept,
  input logic             tmo_fire
);

  p_int_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ev_last |=> !int_n);

  p_busy_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push && busy && !pop |=> $stable(occ));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  p_int_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> occ != '0);

  p_empty_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    occ == '0 |-> status == 8'h00);

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop && status[7] && !ev_push |=> status[5:0] > $past(status[5:0]));

  p_pop_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop && (occ != '0) && !ev_push |=> occ == $past(occ) - 1'b1);

  p_tmo_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> int_n);

endmodule

bind kev_top kev_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev_push  (ev_push),
  .ev_last  (ev_last),
  .pop      (pop),
  .busy     (busy),
  .int_n    (int_n),
  .status   (status),
  .occ      (occ),
  .accept   (accept),
  .tmo_fire (tmo_fire)
);

// File: tb/kev_top_tb.sv
module kev_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_push = 1'b0;
  logic [5:0] ev_code = '0;
  logic       ev_pressed = 1'b0;
  logic       ev_last = 1'b0;
  logic       pop = 1'b0;
  logic [1:0] aci = 2'b00;
  logic       ms_tick = 1'b0;
  logic [7:0] status;
  logic       int_n;
  logic       busy;
  logic       ovf_seen;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  kev_top u_dut (
    .clk(clk), .rst_n(rst_n), .ev_push(ev_push), .ev_code(ev_code),
    .ev_pressed(ev_pressed), .ev_last(ev_last), .pop(pop), .aci(aci),
    .ms_tick(ms_tick), .status(status), .int_n(int_n), .busy(busy),
    .ovf_seen(ovf_seen)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sb(input bit more, input bit pr, input int code);
    return {more, pr, 6'(code)};
  endfunction

  task automatic push_ev(input int code, input bit pr, input bit last);
    @(negedge clk);
    ev_push = 1'b1; ev_code = 6'(code); ev_pressed = pr; ev_last = last;
    @(negedge clk);
    ev_push = 1'b0; ev_last = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] exp);
    check(req, status, exp);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R10 status", status, 8'h00);
    check("R10 int_n", {7'd0, int_n}, 8'h01);
    check("R10 busy", {7'd0, busy}, 8'h00);
    check("R10 ovf", {7'd0, ovf_seen}, 8'h00);
  endtask

  task automatic t_single;
    push_ev(25, 1'b1, 1'b1);
    check("R4 int low", {7'd0, int_n}, 8'h00);
    check("R4 busy", {7'd0, busy}, 8'h01);
    pop_expect("R1 byte", 8'h59);
    check("R5 int high", {7'd0, int_n}, 8'h01);
    check("R5 status 00", status, 8'h00);
    push_ev(52, 1'b0, 1'b1);
    pop_expect("R1 release byte", 8'h34);
  endtask

  task automatic t_order;
    push_ev(59, 1'b1, 1'b0);
    push_ev(34, 1'b0, 1'b0);
    push_ev(5, 1'b1, 1'b1);
    pop_expect("R2 first", sb(1, 1, 5));
    check("R5 int held", {7'd0, int_n}, 8'h00);
    pop_expect("R2 second", sb(1, 0, 34));
    pop_expect("R2 third", sb(0, 1, 59));
    check("R5 int released", {7'd0, int_n}, 8'h01);
  endtask

  task automatic t_ignore_busy;
    push_ev(10, 1'b1, 1'b1);
    push_ev(3, 1'b1, 1'b1);
    check("R4 ignored push", status, sb(0, 1, 10));
    pop_expect("R4 only original", sb(0, 1, 10));
    check("R4 nothing left", status, 8'h00);
  endtask

  task automatic t_empty_pop;
    pop_expect("R9 empty read", 8'h00);
    check("R9 int unchanged", {7'd0, int_n}, 8'h01);
    check("R9 still empty", status, 8'h00);
  endtask

  task automatic t_aci_short;
    aci = 2'b01;
    push_ev(40, 1'b1, 1'b0);
    push_ev(7, 1'b0, 1'b1);
    ticks(4);
    check("R6 low at 4", {7'd0, int_n}, 8'h00);
    ticks(1);
    check("R6 high at 5", {7'd0, int_n}, 8'h01);
    check("R7 data kept", status, sb(1, 0, 7));
    pop_expect("R7 read int high", sb(1, 0, 7));
    push_ev(12, 1'b1, 1'b1);
    check("R8 int again", {7'd0, int_n}, 8'h00);
    pop_expect("R8 new only", sb(0, 1, 12));
    check("R8 old lost", status, 8'h00);
    check("R8 int released", {7'd0, int_n}, 8'h01);
  endtask

  task automatic t_aci_long;
    aci = 2'b10;
    push_ev(1, 1'b1, 1'b1);
    ticks(9);
    check("R6 low at 9", {7'd0, int_n}, 8'h00);
    ticks(1);
    check("R6 high at 10", {7'd0, int_n}, 8'h01);
    pop_expect("R7 drain", sb(0, 1, 1));
  endtask

  task automatic t_aci_off;
    aci = 2'b00;
    push_ev(2, 1'b1, 1'b1);
    ticks(20);
    check("R6 off holds", {7'd0, int_n}, 8'h00);
    aci = 2'b11;
    ticks(12);
    check("R6 code 11 holds", {7'd0, int_n}, 8'h00);
    pop_expect("R6 drain", sb(0, 1, 2));
  endtask

  task automatic t_cancel;
    aci = 2'b01;
    push_ev(20, 1'b1, 1'b0);
    push_ev(30, 1'b1, 1'b1);
    pop_expect("R11 first", sb(1, 1, 20));
    ticks(12);
    check("R11 timeout cancelled", {7'd0, int_n}, 8'h00);
    pop_expect("R11 last", sb(0, 1, 30));
    check("R11 released", {7'd0, int_n}, 8'h01);
    aci = 2'b00;
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 17; i++) push_ev(i, 1'b1, i == 16);
    check("R3 ovf flag", {7'd0, ovf_seen}, 8'h01);
    for (int i = 0; i < 16; i++) pop_expect("R3 drain", sb(i < 15, 1, i));
    check("R3 extra dropped", status, 8'h00);
    check("R3 int high", {7'd0, int_n}, 8'h01);
    check("R3 ovf sticky", {7'd0, ovf_seen}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_ignore_busy();
    t_empty_pop();
    t_aci_short();
    t_aci_long();
    t_aci_off();
    t_cancel();
    t_overflow();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule